// File: doc/BRIEF.md
# Serial Scrambler and NRZI Line Encoder

This block turns parallel 20-bit words into a serial bit stream for a high-rate video link. Each word is taken on a one-cycle load strobe and then sent one bit per serial clock, least significant bit first. Every bit passes through a self-synchronizing scrambler built on x^9 + x^4 + 1 and then through an NRZ-to-NRZI converter (x + 1) before it is registered onto the single output pin. A word loaded on the cycle that sends the last bit of the previous word follows it with no gap. A load strobe at any other time while a word is being sent is dropped, so word alignment is never lost.

Three controls change the path. `bypass` routes the raw serialized bits straight to the output and freezes both coding registers. `scr_clear` holds the scrambler history and the NRZI state at zero. `mute` stalls the whole datapath, so the output pin keeps its last value. The block sits behind a word interleaver and in front of a clock multiplier and line driver. Those parts are not included here.

Top module: `ser_scramble_tx`

## Requirements
- R1: While `rst` is high, and on the cycle after it falls, `sout` is 0 and no word is in flight.
- R2: After a load accepted at clock edge E0, bit k of that word (k = 0 is the LSB) sets `sout` at edge E0+1+k, for k = 0..19.
- R3: A load present on the edge that sends bit 19 of the current word is accepted, and its bit 0 follows on the next edge with no gap.
- R4: A load while a word is in flight, on any edge other than the one sending bit 19, is ignored. The word in flight continues unchanged.
- R5: With `bypass`, `scr_clear` and `mute` low, the scrambled bit is s = b XOR h4 XOR h9. Here b is the current data bit and hd is the scrambled bit from d bit-times earlier. s is then shifted into the history.
- R6: The NRZI value is n = s XOR (previous NRZI value), and in normal operation `sout` takes n.
- R7: With `bypass` high, `sout` takes the raw data bit, and the scrambler history and NRZI state hold their values.
- R8: While `scr_clear` is high, the scrambler history and the NRZI state are held at zero, so a bit sent in that cycle leaves as the raw bit. Coding resumes from the zero state once it falls.
- R9: While `mute` is high, `sout`, the word in flight, the bit position and the coding state all hold, and a load is ignored.
- R10: When no word is in flight, `sout` holds and the coding state does not advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous active-high block reset |
| load | input | 1 | One-cycle word load strobe |
| din | input | 20 | Parallel word, bit 0 sent first |
| bypass | input | 1 | High: skip scrambler and NRZI, send raw bits |
| scr_clear | input | 1 | High: hold scrambler and NRZI state at zero |
| mute | input | 1 | High: stall the datapath, hold the output |
| sout | output | 1 | Registered serial output bit |

## Verification
The hardest case to reach is a load strobe landing exactly on the edge that sends bit 19. This case is hardest when the edge coincides with mute or with the clear control, because the strobe must then be dropped or accepted according to a stall that started many cycles earlier. The random phase asserts load on about half of all cycles and pulses mute and clear often, so boundary edges meet every combination of controls many times. Directed sequences pin down the exact aligned back-to-back and misaligned loads against known words.

// File: rtl/ser_pkg.sv
package ser_pkg;
  parameter int WORD_W   = 20;
  parameter int HIST_LEN = 9;
  parameter int TAP_NEAR = 4;
endpackage

// File: rtl/ser_shifter.sv
module ser_shifter #(
  parameter int WORD_W = ser_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              mute,
  input  logic [WORD_W-1:0] din,
  output logic              bit_o,
  output logic              adv_o,
  output logic              active_o
);
  localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  pos_q;
  logic              active_q;
  logic              at_last;
  logic              take;

  assign at_last = active_q && (pos_q == LAST_POS);
  assign take    = load && !mute && (!active_q || at_last);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q     <= '0;
      pos_q    <= '0;
      active_q <= 1'b0;
    end else if (take) begin
      sh_q     <= din;
      pos_q    <= '0;
      active_q <= 1'b1;
    end else if (active_q && !mute) begin
      if (at_last) begin
        active_q <= 1'b0;
        pos_q    <= '0;
      end else begin
        sh_q  <= sh_q >> 1;
        pos_q <= pos_q + 1'b1;
      end
    end
  end

  assign bit_o    = sh_q[0];
  assign adv_o    = active_q && !mute;
  assign active_o = active_q;
endmodule

// File: rtl/ser_scrambler.sv
module ser_scrambler #(
  parameter int HIST_LEN = ser_pkg::HIST_LEN,
  parameter int TAP_NEAR = ser_pkg::TAP_NEAR
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  input  logic bypass,
  input  logic clr,
  input  logic bit_i,
  output logic scr_o
);
  logic [HIST_LEN-1:0] hist_q;
  logic [HIST_LEN-1:0] tap_vec;
  logic                fb;

  // hist_q[d-1] is the scrambled bit from d bit-times ago
  for (genvar i = 0; i < HIST_LEN; i++) begin : g_tap
    if (i == TAP_NEAR - 1 || i == HIST_LEN - 1) begin : g_on
      assign tap_vec[i] = hist_q[i];
    end else begin : g_off
      assign tap_vec[i] = 1'b0;
    end
  end

  assign fb    = ^tap_vec;
  assign scr_o = bit_i ^ (clr ? 1'b0 : fb);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      hist_q <= '0;
    end else if (adv && !bypass) begin
      hist_q <= {hist_q[HIST_LEN-2:0], scr_o};
    end
  end
endmodule

// File: rtl/ser_nrzi.sv
module ser_nrzi (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  input  logic bypass,
  input  logic clr,
  input  logic raw_i,
  input  logic scr_i,
  output logic sout
);
  logic level_q;
  logic nxt;

  assign nxt = scr_i ^ (clr ? 1'b0 : level_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= 1'b0;
      sout    <= 1'b0;
    end else begin
      if (clr) begin
        level_q <= 1'b0;
      end else if (adv && !bypass) begin
        level_q <= nxt;
      end
      if (adv) begin
        sout <= bypass ? raw_i : nxt;
      end
    end
  end
endmodule

// File: rtl/ser_scramble_tx.sv
module ser_scramble_tx #(
  parameter int WORD_W   = ser_pkg::WORD_W,
  parameter int HIST_LEN = ser_pkg::HIST_LEN,
  parameter int TAP_NEAR = ser_pkg::TAP_NEAR
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] din,
  input  logic              bypass,
  input  logic              scr_clear,
  input  logic              mute,
  output logic              sout
);
  logic cur_bit;
  logic adv;
  logic active;
  logic scr_bit;

  ser_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .load(load), .mute(mute), .din(din),
    .bit_o(cur_bit), .adv_o(adv), .active_o(active)
  );

  ser_scrambler #(.HIST_LEN(HIST_LEN), .TAP_NEAR(TAP_NEAR)) u_scr (
    .clk(clk), .rst(rst), .adv(adv), .bypass(bypass), .clr(scr_clear),
    .bit_i(cur_bit), .scr_o(scr_bit)
  );

  ser_nrzi u_nrzi (
    .clk(clk), .rst(rst), .adv(adv), .bypass(bypass), .clr(scr_clear),
    .raw_i(cur_bit), .scr_i(scr_bit), .sout(sout)
  );
endmodule

// File: rtl/ser_scramble_tx_chk.sv
module ser_scramble_tx_chk (
  input logic clk,
  input logic rst,
  input logic mute,
  input logic bypass,
  input logic scr_clear,
  input logic adv,
  input logic active,
  input logic cur_bit,
  input logic sout
);
  p_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (sout == 1'b0 && !active));

  p_mute_hold_r9: assert property (@(posedge clk) disable iff (rst)
    mute |=> $stable(sout));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(sout));

  p_bypass_raw_r7: assert property (@(posedge clk) disable iff (rst)
    (adv && bypass) |=> (sout == $past(cur_bit)));

  p_clear_raw_r8: assert property (@(posedge clk) disable iff (rst)
    (adv && scr_clear) |=> (sout == $past(cur_bit)));
endmodule

bind ser_scramble_tx ser_scramble_tx_chk u_chk (
  .clk(clk), .rst(rst), .mute(mute), .bypass(bypass), .scr_clear(scr_clear),
  .adv(adv), .active(active), .cur_bit(cur_bit), .sout(sout)
);

// File: tb/ser_scramble_tx_test.sv
module ser_scramble_tx_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load = 1'b0;
  logic [19:0] din = '0;
  logic        bypass = 1'b0;
  logic        scr_clear = 1'b0;
  logic        mute = 1'b0;
  logic        sout;

  int checks = 0;
  int fails  = 0;

  ser_scramble_tx uut (
    .clk(clk), .rst(rst), .load(load), .din(din), .bypass(bypass),
    .scr_clear(scr_clear), .mute(mute), .sout(sout)
  );

  always #4 clk = ~clk;

  // reference model state
  logic        m_active = 1'b0;
  int          m_pos = 0;
  logic [19:0] m_sh = '0;
  logic [8:0]  m_hist = '0;
  logic        m_nrzi = 1'b0;
  logic        m_out = 1'b0;

  string prev_tag = "";
  logic  prev_exp_en = 1'b0;
  logic  prev_exp_bit = 1'b0;
  string prev_exp_tag = "";

  task automatic check(input logic ok, input string tag, input logic act, input logic exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: sout=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge(input logic ld, input logic [19:0] d, input logic byp,
                            input logic clr, input logic mt, input logic rs);
    logic adv, b, s, n;
    if (rs) begin
      m_active = 0; m_pos = 0; m_sh = '0; m_hist = '0; m_nrzi = 0; m_out = 0;
      return;
    end
    adv = m_active && !mt;
    b = m_sh[0];
    if (adv) begin
      if (byp) begin
        m_out = b;
      end else begin
        s = b ^ (clr ? 1'b0 : (m_hist[3] ^ m_hist[8]));
        n = s ^ (clr ? 1'b0 : m_nrzi);
        m_out = n;
        if (!clr) begin
          m_hist = {m_hist[7:0], s};
          m_nrzi = n;
        end
      end
    end
    if (clr) begin
      m_hist = '0;
      m_nrzi = 0;
    end
    if (!mt) begin
      if (ld && (!m_active || m_pos == 19)) begin
        m_sh = d; m_pos = 0; m_active = 1;
      end else if (m_active) begin
        if (m_pos == 19) begin
          m_active = 0; m_pos = 0;
        end else begin
          m_sh = m_sh >> 1; m_pos++;
        end
      end
    end
  endtask

  task automatic step(input logic ld, input logic [19:0] d, input logic byp,
                      input logic clr, input logic mt, input logic rs,
                      input logic exp_en, input logic exp_bit, input string exp_tag);
    string tag;
    @(negedge clk);
    if (prev_tag != "") check(sout === m_out, prev_tag, sout, m_out);
    if (prev_exp_en) check(sout === prev_exp_bit, prev_exp_tag, sout, prev_exp_bit);
    load = ld; din = d; bypass = byp; scr_clear = clr; mute = mt; rst = rs;
    if (rs) tag = "R1";
    else if (mt) tag = "R9";
    else if (!m_active) tag = "R10";
    else if (clr) tag = "R8";
    else if (byp) tag = "R7";
    else tag = "R5 R6";
    model_edge(ld, d, byp, clr, mt, rs);
    prev_tag = tag;
    prev_exp_en = exp_en;
    prev_exp_bit = exp_bit;
    prev_exp_tag = exp_tag;
  endtask

  initial begin
    #1_500_000;
    $display("FAIL watchdog expired");
    fails++;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [19:0] w1, w2, w3, w4;
    void'($urandom(32'h00C0FFEE));
    w1 = 20'hA5F3C; w2 = 20'h3C96E; w3 = 20'hFFFFF; w4 = 20'h1B7D2;

    for (int i = 0; i < 3; i++) step(0, '0, 0, 0, 0, 1, 0, 0, "");
    // R1: after reset falls, output low
    step(0, '0, 0, 0, 0, 0, 1, 1'b0, "R1");
    for (int i = 0; i < 3; i++) step(0, '0, 1, 0, 0, 0, 1, 1'b0, "R10");

    // R2 / R3 / R4: bypass, known words
    step(1, w1, 1, 0, 0, 0, 1, 1'b0, "R10");
    for (int k = 0; k < 20; k++) step(k == 19, w2, 1, 0, 0, 0, 1, w1[k], "R2");
    for (int k = 0; k < 20; k++)
      step(k == 5, w3, 1, 0, 0, 0, 1, w2[k], (k >= 5) ? "R4" : "R3");
    for (int i = 0; i < 3; i++) step(0, '0, 1, 0, 0, 0, 1, w2[19], "R10");

    // R9: mute mid-word holds output and position
    step(1, w4, 1, 0, 0, 0, 0, 0, "");
    for (int k = 0; k < 6; k++) step(0, '0, 1, 0, 0, 0, 1, w4[k], "R2");
    for (int i = 0; i < 4; i++) step(1, w3, 1, 0, 1, 0, 1, w4[5], "R9");
    for (int k = 6; k < 20; k++) step(0, '0, 1, 0, 0, 0, 1, w4[k], "R9");

    // R8: clear gives raw bits with coding on
    step(1, w1, 0, 1, 0, 0, 0, 0, "");
    for (int k = 0; k < 20; k++) step(0, '0, 0, 1, 0, 0, 1, w1[k], "R8");
    // R5 R6: coding from zero state, model-checked
    step(1, w3, 0, 0, 0, 0, 0, 0, "");
    for (int k = 0; k < 25; k++) step(k == 19, w2, 0, 0, 0, 0, 0, 0, "");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic ld, byp, clr, mt;
      ld  = ($urandom % 2) == 0;
      byp = ($urandom % 8) == 0;
      clr = ($urandom % 20) == 0;
      mt  = ($urandom % 10) == 0;
      step(ld, 20'($urandom), byp, clr, mt, 1'b0, 0, 0, "");
    end
    step(0, '0, 0, 0, 0, 0, 0, 0, "");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule